// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable sum-of-products device. It takes an already computed OR-sum, a per-cell output-enable term, the device-wide asynchronous clear and synchronous set terms, a power-on reset, and the value seen on the cell's own pin. Four configuration bits decide what the cell does with them. The result is a pad data value, a three-state enable for the pad driver, and a feedback bit for the logic array.

Inside the cell there is a single D flip-flop. It is modelled as a two-state machine with the states `ST_LOW` and `ST_HIGH`, and it moves between them through four named transitions. LOAD_HIGH and LOAD_LOW take the sum on the rising edge of the selected clock. PRESET forces `ST_HIGH` on that edge. CLEAR forces `ST_LOW` at once, with no clock edge needed. Around the flip-flop, three selections are made. The pad value comes either from the flip-flop or straight from the sum. The pad value can be inverted. The feedback comes either from the flip-flop or from the pin. The flip-flop's clock is one of two clock inputs.

Configuration word `cfg[3:0]`: bit 0 `act_high`, bit 1 `bypass`, bit 2 `clk_pick`, bit 3 `fb_swap`. An unprogrammed cell holds every bit at 1.

Top module: `config_macrocell`

## Requirements
- R1: `cfg[0]`=1 drives the selected path value to `pad_out` unchanged, and `cfg[0]`=0 drives its inverse. This applies to both the registered and the combinational path.
- R2: With `cfg[1]`=0, `pad_out` is derived from the flip-flop, which captures `sum_in` on the selected clock's rising edge. With `cfg[1]`=1, `pad_out` follows `sum_in` in the same cycle.
- R3: `cfg[2]`=1 clocks the flip-flop from `clk_a`, and `cfg[2]`=0 clocks it from `clk_b`. Rising edges of the clock that is not selected leave the flip-flop unchanged.
- R4: Feedback comes from the flip-flop when `cfg[3]` differs from `cfg[1]`, and from the pin when they are equal. So with `cfg[3]`=1, a registered cell feeds back the register and a combinational cell feeds back the pin; `cfg[3]`=0 reverses both.
- R5: `ar_term`=1 moves the flip-flop to `ST_LOW` immediately (CLEAR), without waiting for any clock edge.
- R6: `sp_term`=1 moves the flip-flop to `ST_HIGH` on the next rising edge of the selected clock (PRESET), and not before that edge.
- R7: When `ar_term` and `sp_term` are both 1, the flip-flop stays in `ST_LOW`.
- R8: `por`=1 holds the flip-flop in `ST_LOW`. During that time a registered cell shows 1 on `pad_out` when `cfg[0]`=0 and 0 when `cfg[0]`=1.
- R9: `pad_oe` equals `oe_term`. Pin feedback returns `pin_in` while `oe_term`=0, and the cell's own `pad_out` while `oe_term`=1.
- R10: The unprogrammed code `cfg`=4'b1111 gives a combinational, non-inverted cell with pin feedback, clocked from `clk_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First clock source |
| clk_b | input | 1 | Second clock source |
| por | input | 1 | Power-on reset, active high, asynchronous |
| cfg | input | 4 | Configuration bits {fb_swap, clk_pick, bypass, act_high} |
| sum_in | input | 1 | OR-sum from the logic array |
| oe_term | input | 1 | Output-enable product term |
| pin_in | input | 1 | Value present on the pin from outside |
| ar_term | input | 1 | Asynchronous clear term |
| sp_term | input | 1 | Synchronous set term |
| pad_out | output | 1 | Data value for the pad driver |
| pad_oe | output | 1 | Enable for the pad driver |
| fb_out | output | 1 | Feedback bit to the logic array |

## Verification
The bench builds the cell with the package defaults, a four-bit configuration word and a one-bit data path. At that size every configuration code can be driven directly, and the vector table covers most of the sixteen codes, on both clocks. `clk_b` is pulsed by hand while `clk_a` runs freely. This makes it possible to show that an edge on the clock that is not selected has no effect. It also allows the clear to be observed between edges, and the preset to be seen waiting for its edge.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

    localparam int CFG_W = 4;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } cell_state_e;

    typedef struct packed {
        logic fb_swap;
        logic clk_pick;
        logic bypass;
        logic act_high;
    } cell_cfg_t;

endpackage

// File: rtl/mc_clock_pick.sv
module mc_clock_pick (
    input  logic clk_a,
    input  logic clk_b,
    input  logic pick_a,
    output logic clk_out
);
    // Route one of the two clock sources to the flip-flop.
    // The select must only change while both sources are low.
    assign clk_out = pick_a ? clk_a : clk_b;
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import macrocell_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        preset,
    input  logic        d,
    output cell_state_e state_q
);
    cell_state_e state_d;

    // Next-state logic. A preset always wins over the sum.
    always_comb begin
        unique case (state_q)
            ST_LOW:  state_d = (preset || d) ? ST_HIGH : ST_LOW;   // PRESET / LOAD_HIGH
            ST_HIGH: state_d = (preset || d) ? ST_HIGH : ST_LOW;   // PRESET / LOAD_LOW
            default: state_d = ST_LOW;
        endcase
    end

    // State register. CLEAR acts without waiting for a clock edge.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            state_q <= ST_LOW;
        else
            state_q <= state_d;
    end

    // R2: with no preset, the flip-flop holds the sum captured on the previous edge.
    assert_capture_R2: assert property (@(posedge clk) disable iff (clr)
        !preset |=> (state_q == cell_state_e'($past(d))));

    // R6: a preset takes effect on the next edge of the selected clock.
    assert_preset_high_R6: assert property (@(posedge clk) disable iff (clr)
        preset |=> (state_q == ST_HIGH));
endmodule

// File: rtl/mc_route.sv
module mc_route
    import macrocell_pkg::*;
(
    input  logic        act_high,
    input  logic        bypass,
    input  logic        fb_swap,
    input  logic        sum,
    input  cell_state_e state,
    input  logic        oe,
    input  logic        pin_in,
    output logic        pad_out,
    output logic        pad_oe,
    output logic        fb
);
    logic path_val;
    logic pin_val;
    logic from_reg;

    always_comb begin
        path_val = bypass ? sum : logic'(state);
        pad_out  = act_high ? path_val : ~path_val;
        pad_oe   = oe;
        // A driven pin reads back the cell's own value.
        pin_val  = oe ? pad_out : pin_in;
        // The default pairing is register feedback for a registered cell;
        // fb_swap=0 reverses that pairing.
        from_reg = fb_swap ? ~bypass : bypass;
        fb       = from_reg ? logic'(state) : pin_val;
    end
endmodule

// File: rtl/config_macrocell.sv
module config_macrocell
    import macrocell_pkg::*;
(
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             por,
    input  logic [CFG_W-1:0] cfg,
    input  logic             sum_in,
    input  logic             oe_term,
    input  logic             pin_in,
    input  logic             ar_term,
    input  logic             sp_term,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             fb_out
);
    cell_cfg_t   cfg_s;
    cell_state_e state;
    logic        ff_clk;
    logic        clr;

    assign cfg_s = cell_cfg_t'(cfg);
    assign clr   = ar_term | por;

    mc_clock_pick u_clk (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .pick_a  (cfg_s.clk_pick),
        .clk_out (ff_clk)
    );

    mc_state_reg u_ff (
        .clk     (ff_clk),
        .clr     (clr),
        .preset  (sp_term),
        .d       (sum_in),
        .state_q (state)
    );

    mc_route u_route (
        .act_high (cfg_s.act_high),
        .bypass   (cfg_s.bypass),
        .fb_swap  (cfg_s.fb_swap),
        .sum      (sum_in),
        .state    (state),
        .oe       (oe_term),
        .pin_in   (pin_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .fb       (fb_out)
    );

    assert_async_clear_R5: assert property (@(posedge clk_a) disable iff (por)
        ar_term |-> (state == ST_LOW));

    assert_reset_wins_R7: assert property (@(posedge clk_a) disable iff (por)
        (ar_term && sp_term) |-> (state == ST_LOW));

    assert_reg_polarity_R1: assert property (@(posedge clk_a) disable iff (por)
        !cfg[1] |-> (pad_out == (cfg[0] ? logic'(state) : ~logic'(state))));

    assert_fb_pin_R9: assert property (@(posedge clk_a) disable iff (por)
        ((cfg[3] == cfg[1]) && !oe_term) |-> (fb_out == pin_in));

    assert_fb_reg_R4: assert property (@(posedge clk_a) disable iff (por)
        (cfg[3] != cfg[1]) |-> (fb_out == logic'(state)));
endmodule

// File: tb/sim_config_macrocell.sv
`timescale 1ns/1ps
module sim_config_macrocell;
    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       por   = 1'b1;
    logic [3:0] cfg   = 4'b1111;
    logic       sum_in = 1'b0, oe_term = 1'b1, pin_in = 1'b0;
    logic       ar_term = 1'b0, sp_term = 1'b0;
    logic       pad_out, pad_oe, fb_out;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk_a = ~clk_a;   // 125 MHz

    config_macrocell u0 (
        .clk_a(clk_a), .clk_b(clk_b), .por(por), .cfg(cfg),
        .sum_in(sum_in), .oe_term(oe_term), .pin_in(pin_in),
        .ar_term(ar_term), .sp_term(sp_term),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    // {cfg[3:0], sum, sp, ar, oe, pin, exp_out, exp_oe, exp_fb}
    localparam int NV = 16;
    localparam logic [11:0] VECS [0:NV-1] = '{
        12'b1111_1_0_0_1_0_1_1_1,
        12'b1101_0_0_0_1_0_0_1_0,
        12'b1101_1_0_0_1_0_1_1_1,
        12'b1100_1_0_0_1_0_0_1_1,
        12'b1100_0_1_0_1_0_0_1_1,
        12'b1100_0_0_1_1_0_1_1_0,
        12'b1101_1_1_1_1_0_0_1_0,
        12'b0101_1_0_0_0_0_1_0_0,
        12'b0101_0_0_0_0_1_0_0_1,
        12'b0101_1_0_0_1_0_1_1_1,
        12'b0111_0_0_0_1_0_0_1_0,
        12'b0010_1_0_0_1_0_0_1_1,
        12'b1010_0_0_0_1_0_1_1_1,
        12'b0001_1_0_0_0_0_1_0_0,
        12'b1000_0_0_0_1_1_1_1_0,
        12'b1011_1_0_0_0_0_1_0_0
    };

    function automatic string vtag(input int i);
        case (i)
            0:  return "R10";
            1, 2: return "R2";
            3, 12: return "R1";
            4:  return "R6";
            5:  return "R5";
            6:  return "R7";
            7, 8, 15: return "R9";
            11, 13: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic pulse_b();
        #1 clk_b = 1'b1;
        #1 clk_b = 1'b0;
        #1;
    endtask

    initial begin
        // R8: power-on reset holds the flip-flop low; the pin level follows polarity.
        cfg = 4'b1100; sum_in = 1'b1;
        repeat (3) @(posedge clk_a);
        #2 check("R8", "pad_out active-low", pad_out, 1'b1);
        check("R8", "fb_out", fb_out, 1'b0);
        cfg = 4'b1101;
        #1 check("R8", "pad_out active-high", pad_out, 1'b0);
        @(negedge clk_a);
        por = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk_a);
            cfg     = VECS[i][11:8];
            sum_in  = VECS[i][7];
            sp_term = VECS[i][6];
            ar_term = VECS[i][5];
            oe_term = VECS[i][4];
            pin_in  = VECS[i][3];
            if (VECS[i][10]) begin
                @(posedge clk_a);
                #2;
            end else begin
                pulse_b();
            end
            check(vtag(i), "pad_out", pad_out, VECS[i][2]);
            check(vtag(i), "pad_oe",  pad_oe,  VECS[i][1]);
            check(vtag(i), "fb_out",  fb_out,  VECS[i][0]);
        end

        // R3: the unselected clock has no effect.
        @(negedge clk_a);
        cfg = 4'b1001; sum_in = 1'b0; sp_term = 1'b0; ar_term = 1'b0; oe_term = 1'b1;
        pulse_b();
        sum_in = 1'b1;
        repeat (2) @(posedge clk_a);
        #2 check("R3", "pad_out after clk_a edges", pad_out, 1'b0);
        @(negedge clk_a);
        pulse_b();
        check("R3", "pad_out after clk_b edge", pad_out, 1'b1);

        // R5: the clear acts between clock edges.
        @(negedge clk_a);
        cfg = 4'b1101; sum_in = 1'b1;
        @(posedge clk_a);
        #2 check("R5", "pad_out before clear", pad_out, 1'b1);
        @(negedge clk_a);
        ar_term = 1'b1;
        #1 check("R5", "pad_out right after clear", pad_out, 1'b0);
        @(negedge clk_a);
        ar_term = 1'b0; sum_in = 1'b0;

        // R6: the preset waits for the edge.
        @(posedge clk_a);
        @(negedge clk_a);
        sp_term = 1'b1;
        #1 check("R6", "pad_out before edge", pad_out, 1'b0);
        @(posedge clk_a);
        #2 check("R6", "pad_out after edge", pad_out, 1'b1);
        @(negedge clk_a);
        sp_term = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_a);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule